// File: doc/BRIEF.md
# Voltage-Frequency Scaling Sequencer

This controller moves a system between sixteen performance levels. Software writes a target frequency code. The block then drives a frequency code to a programmable clock generator and a 5-bit supply code to a regulator. It reads back two handshakes: one that says the supply has settled and one that says the clock has locked. For every frequency code, the supply code comes from a constant table that is computed inside the block. The table gives the lowest supply level that still meets timing at that frequency.

The block orders each change by its direction, so that the logic never runs faster than its supply allows. On a step up, the supply rises first, and the clock follows once the regulator reports a settled supply. On a step down, the clock falls first, and the supply follows once the clock generator reports lock. A request that arrives during a transition is held, and a newer request replaces it. Each handshake wait is limited by a programmable cycle count. When that count runs out, the block stops at a safe state and flags a fault.

Top module: `dvfs_sequencer`

## Requirements
- R1: After reset, the frequency code is 0 and the supply code is 0. Busy and fault are both low.
- R2: For frequency code f (0..15), the supply code issued for f is ceil(31*f/15). After a completed transition to f, the supply code equals this value.
- R3: On a step up, the supply code changes first. The frequency code rises to the target only on the clock edge at which the settled input is sampled high.
- R4: At all times the supply code is at least the table value of the current frequency code.
- R5: On a step down, the frequency code falls first. The supply code falls only on an edge at which the locked input is sampled high. The two codes never change on the same edge.
- R6: Busy is high from the edge that captures a request until the transition for that request completes. It is low when idle.
- R7: A request captured while busy is held, and a later request replaces it. When the current transition ends, only the newest held request is served.
- R8: A request equal to the current frequency code leaves both codes unchanged.
- R9: A request is captured on an edge where req_valid is high. The transition starts on the next edge.
- R10: If a handshake stays low for wait_limit wait cycles (wait_limit >= 1), the fault output rises on the (wait_limit+1)-th edge after the capturing edge. At that point the supply code goes to 31 and the frequency code is left as it stands.
- R11: The fault state persists until reset. Requests made during a fault change neither code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_freq | input | 4 | Requested frequency code |
| wait_limit | input | 16 | Cycle limit for each handshake wait |
| supply_ok | input | 1 | Regulator reports settled supply |
| clock_locked | input | 1 | Clock generator reports lock |
| freq_code | output | 4 | Frequency code to clock generator |
| volt_code | output | 5 | Supply code to regulator (0 = lowest) |
| busy | output | 1 | Transition or held request in progress |
| fault | output | 1 | Handshake timeout occurred |

## Verification
The capturing edge raises busy, so busy is sampled at the falling edge right after it. The first code change comes one edge later. The final code change lands on the edge that samples the handshake high. The bench therefore waits on busy falling and then compares both codes with the table formula.

A per-cycle monitor runs at each falling edge. It compares every code change against the handshake value sampled one half-cycle before, which enforces the ordering rules without knowing how long each responder takes. The timeout is checked by counting edges from the capturing edge to the fault, and the expected count is wait_limit+1.

// File: rtl/dvfs_sequencer.sv
module dvfs_sequencer #(
  parameter int FW = 4,
  parameter int VW = 5,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [FW-1:0] req_freq,
  input  logic [TW-1:0] wait_limit,
  input  logic          supply_ok,
  input  logic          clock_locked,
  output logic [FW-1:0] freq_code,
  output logic [VW-1:0] volt_code,
  output logic          busy,
  output logic          fault
);
  localparam int FMAX = (1 << FW) - 1;
  localparam int VMAX = (1 << VW) - 1;

  function automatic logic [VW-1:0] vmin(input logic [FW-1:0] f);
    int p;
    p = (int'(f) * VMAX + FMAX - 1) / FMAX;
    return VW'(p);
  endfunction

  typedef enum logic [1:0] {S_IDLE, S_RAISE, S_LOWER, S_FAULT} st_t;

  st_t           state;
  logic          pend_v;
  logic [FW-1:0] pend_f;
  logic [FW-1:0] tgt_f;
  logic [TW-1:0] wcnt;
  logic          expired;

  assign expired = ({1'b0, wcnt} + 1'b1) >= {1'b0, wait_limit};
  assign busy    = pend_v | (state == S_RAISE) | (state == S_LOWER);
  assign fault   = (state == S_FAULT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      pend_v    <= 1'b0;
      pend_f    <= '0;
      tgt_f     <= '0;
      wcnt      <= '0;
      freq_code <= '0;
      volt_code <= vmin('0);
    end else begin
      case (state)
        S_IDLE: if (pend_v) begin
          pend_v <= 1'b0;
          tgt_f  <= pend_f;
          wcnt   <= '0;
          if (pend_f > freq_code) begin
            volt_code <= vmin(pend_f);
            state     <= S_RAISE;
          end else if (pend_f < freq_code) begin
            freq_code <= pend_f;
            state     <= S_LOWER;
          end
        end
        S_RAISE: begin
          if (supply_ok) begin
            freq_code <= tgt_f;
            state     <= S_IDLE;
          end else if (expired) begin
            volt_code <= VW'(VMAX);
            state     <= S_FAULT;
          end else wcnt <= wcnt + 1'b1;
        end
        S_LOWER: begin
          if (clock_locked) begin
            volt_code <= vmin(tgt_f);
            state     <= S_IDLE;
          end else if (expired) begin
            volt_code <= VW'(VMAX);
            state     <= S_FAULT;
          end else wcnt <= wcnt + 1'b1;
        end
        default: ;
      endcase
      if (req_valid && state != S_FAULT) begin
        pend_v <= 1'b1;
        pend_f <= req_freq;
      end
    end
  end

  assert_supply_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    volt_code >= vmin(freq_code));

  assert_no_joint_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !((freq_code != $past(freq_code)) && (volt_code != $past(volt_code))));

  assert_up_after_settle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_code > $past(freq_code)) |-> $past(supply_ok));

  assert_fault_safe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (volt_code == VW'(VMAX)));

  assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (fault && $stable(freq_code) && $stable(volt_code)));
endmodule

// File: tb/sim_dvfs_sequencer.sv
module sim_dvfs_sequencer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_freq = '0;
  logic [15:0] wait_limit = 16'd1000;
  logic        supply_ok, clock_locked;
  logic [3:0]  freq_code;
  logic [4:0]  volt_code;
  logic        busy, fault;

  int checks = 0;
  int errors = 0;
  int reg_delay = 3;
  int pll_delay = 2;
  logic [4:0] vlast;
  logic [3:0] flast;
  int vcnt, fcnt;
  logic seen_stale = 1'b0;
  logic mon_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dvfs_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_freq(req_freq),
    .wait_limit(wait_limit), .supply_ok(supply_ok), .clock_locked(clock_locked),
    .freq_code(freq_code), .volt_code(volt_code), .busy(busy), .fault(fault));

  always_ff @(posedge clk) begin
    vlast <= volt_code;
    flast <= freq_code;
    if (volt_code != vlast) vcnt <= 0; else if (vcnt < 100000) vcnt <= vcnt + 1;
    if (freq_code != flast) fcnt <= 0; else if (fcnt < 100000) fcnt <= fcnt + 1;
  end
  assign supply_ok    = (reg_delay >= 0) && (volt_code == vlast) && (vcnt >= reg_delay);
  assign clock_locked = (pll_delay >= 0) && (freq_code == flast) && (fcnt >= pll_delay);

  function automatic int vtab(input int f);
    return (f * 31 + 14) / 15;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  logic [3:0] pf;
  logic [4:0] pv;
  logic ps, pl;
  always @(negedge clk) begin
    if (mon_on) begin
      if (freq_code == 4'd3) seen_stale = 1'b1;
      if (volt_code < vtab(freq_code)) chk(0, "R4 supply floor", volt_code, vtab(freq_code));
      if (freq_code != pf && volt_code != pv) chk(0, "R5 joint step", freq_code, pf);
      if (freq_code > pf) chk(ps && pv >= vtab(freq_code), "R3 raise order", ps, 1);
      if (volt_code < pv) chk(pl && freq_code == pf, "R5 lower order", pl, 1);
    end
    pf = freq_code; pv = volt_code; ps = supply_ok; pl = clock_locked;
  end

  task automatic send(input int f);
    @(negedge clk); req_valid = 1'b1; req_freq = 4'(f);
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  task automatic do_reset;
    mon_on = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; @(negedge clk); mon_on = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk(freq_code == 0, "R1 reset freq", freq_code, 0);
    chk(volt_code == 0, "R1 reset volt", volt_code, 0);
    chk(!busy && !fault, "R1 reset flags", {busy, fault}, 0);

    // R9: capture edge raises busy; first change one edge later
    @(negedge clk); req_valid = 1'b1; req_freq = 4'd9;
    @(negedge clk); req_valid = 1'b0;
    chk(busy && volt_code == 0, "R9 capture", volt_code, 0);
    @(negedge clk);
    chk(volt_code == vtab(9) && freq_code == 0, "R9 start edge", volt_code, vtab(9));
    chk(busy, "R6 busy during wait", busy, 1);
    wait_idle();
    chk(freq_code == 9, "R3 up result", freq_code, 9);
    chk(!busy, "R6 idle after", busy, 0);

    // R2/R3/R5 exhaustive pairs
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        send(a); wait_idle();
        send(b); wait_idle();
        chk(freq_code == b, "R2 freq", freq_code, b);
        chk(volt_code == vtab(b), "R2 table", volt_code, vtab(b));
      end
    end

    // R8: equal request
    send(6); wait_idle();
    send(6);
    for (int i = 0; i < 5; i++) begin
      chk(freq_code == 6 && volt_code == vtab(6), "R8 no change", volt_code, vtab(6));
      @(negedge clk);
    end

    // R7: latest request wins
    send(0); wait_idle();
    reg_delay = 20; seen_stale = 1'b0;
    send(10);
    repeat (3) @(negedge clk);
    send(3); send(12);
    wait_idle();
    chk(freq_code == 12, "R7 newest served", freq_code, 12);
    chk(!seen_stale, "R7 stale skipped", seen_stale, 0);
    reg_delay = 3;

    // R10: raise timeout
    wait_limit = 16'd5; reg_delay = -1;
    @(negedge clk); req_valid = 1'b1; req_freq = 4'd14;
    @(posedge clk); #1 req_valid = 1'b0;
    begin
      int n = 0;
      while (!fault && n < 100) begin @(posedge clk); #1 n++; end
      chk(n == 6, "R10 timeout edges", n, 6);
    end
    @(negedge clk);
    chk(volt_code == 31 && freq_code == 12, "R10 safe state", volt_code, 31);
    send(2); repeat (5) @(negedge clk);
    chk(fault && freq_code == 12 && volt_code == 31, "R11 ignored", freq_code, 12);

    // R10: lower timeout
    reg_delay = 3; wait_limit = 16'd1000;
    do_reset();
    send(8); wait_idle();
    pll_delay = -1; wait_limit = 16'd4;
    send(2); repeat (10) @(negedge clk);
    chk(fault && freq_code == 2 && volt_code == 31, "R10 lower safe", volt_code, 31);
    do_reset();
    chk(!fault && freq_code == 0, "R11 cleared by reset", fault, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule